// File: doc/BRIEF.md
# Systolic FIR Multiply-Accumulate Cell

This block is one processing element of a systolic FIR filter array. On every clock it multiplies an 8-bit coefficient by an 8-bit data sample and adds the 18-bit product into a 26-bit running sum. Each operand carries its own format flag, so the cell can treat it as either unsigned or two's complement. Coefficients travel through the cell toward the next cell. A 2-bit delay code picks whether a coefficient leaves straight from the coefficient register or after one, two or three more register stages, which is how an array decimates by 2, 3 or 4. The data sample is meant to be broadcast to every cell at once.

Each cell builds one output point. When the array addresses the cell with a select strobe and a clear strobe, the accumulator drops its old total and starts again from the incoming product. A separate hold register keeps the finished total visible for that clock, so consecutive output points need no idle cycle between them. All control inputs (reset, clear, select, both load enables and the delay code) are captured in a register first and act one clock after they are presented. Reset is synchronous and active high. It clears every register except the accumulator, unless clear is asserted in the same cycle, in which case the accumulator is cleared as well.

Top module: `fir_mac_cell`

## Requirements
- R1: A format flag of 0 makes its operand unsigned (zero-extended to 9 bits), and 1 makes it two's complement (sign-extended). The product of the two 9-bit operands is added to the accumulator with sign extension.
- R2: The accumulator adds one product per clock and wraps modulo 2^26 with no saturation.
- R3: A coefficient/sample pair presented before clock edge k first shows in `result` after edge k+3. The path runs through four register levels: the input registers, two multiplier stages and the hold register.
- R4: `coef_en` acts one clock late. While the captured enable is 0, the coefficient register and the delay registers keep their contents.
- R5: `data_en` acts one clock late. While the captured enable is 0, the sample register loads zero, so that cycle adds nothing.
- R6: With delay code d (0..3), a coefficient loaded at edge k appears on `coef_out` after edge k+d, and its format flag appears on `coef_tc_out` with it.
- R7: When captured `cell_sel` and `acc_clr` are both 1, the accumulator restarts from the current product with no idle cycle. In the clock after any captured select, `result` keeps its previous value.
- R8: `acc_clr` without `cell_sel` clears nothing. `cell_sel` without `acc_clr` only holds `result` for one clock, and the sum continues.
- R9: Captured `rst` alone clears the coefficient, delay, sample, pipeline and hold registers, but the accumulator keeps its total.
- R10: Captured `rst` together with `acc_clr` also clears the accumulator, so `result` reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, acts one clock late |
| acc_clr | input | 1 | Accumulator clear strobe, active high, acts one clock late |
| cell_sel | input | 1 | Cell select strobe, acts one clock late |
| coef_en | input | 1 | Coefficient load enable, acts one clock late |
| coef_in | input | 8 | Coefficient input |
| coef_tc | input | 1 | Coefficient format flag: 1 two's complement, 0 unsigned |
| data_en | input | 1 | Sample load enable, acts one clock late; 0 loads zero |
| data_in | input | 8 | Data sample input |
| data_tc | input | 1 | Sample format flag: 1 two's complement, 0 unsigned |
| dec_sel | input | 2 | Number of extra coefficient delay stages (0..3) |
| coef_out | output | 8 | Coefficient forwarded to the next cell |
| coef_tc_out | output | 1 | Format flag travelling with `coef_out` |
| result | output | 26 | Hold register contents |

## Verification
The assertions assume that every control input is stable around the clock edge, and that reset and clear are not both active in the cycle that a restart property looks at. That case is handled by disabling the properties on the captured reset. The bench changes every input one nanosecond after a rising edge and reads the outputs at the same point. Before each multiply-accumulate sequence it flushes the pipeline with a full clear, so that every sum it checks starts from a known zero. It changes the delay code only while the coefficient path is idle, and lets two clocks pass before it relies on the new code.

// File: rtl/fir_cell_pkg.sv
package fir_cell_pkg;

  // Control strobes captured one clock ahead of use.
  typedef struct packed {
    logic rst;
    logic clr;
    logic sel;
    logic coef_en;
    logic data_en;
  } cell_ctl_t;

endpackage

// File: rtl/fir_cell_ctl.sv
module fir_cell_ctl #(
  parameter int DEC_W = 2
) (
  input  logic                     clk,
  input  fir_cell_pkg::cell_ctl_t  ctl_in,
  input  logic [DEC_W-1:0]         dec_in,
  output fir_cell_pkg::cell_ctl_t  ctl_q,
  output logic [DEC_W-1:0]         dec_q
);

  // Every control acts one clock after it is presented.
  always_ff @(posedge clk) begin
    ctl_q <= ctl_in;
    dec_q <= dec_in;
  end

endmodule

// File: rtl/fir_coef_path.sv
module fir_coef_path #(
  parameter int COEF_W  = 8,
  parameter int DEC_MAX = 3,
  parameter int DEC_W   = 2
) (
  input  logic              clk,
  input  logic              rst_q,
  input  logic              load_q,
  input  logic [DEC_W-1:0]  dec_q,
  input  logic [COEF_W-1:0] coef_in,
  input  logic              coef_tc,
  output logic [COEF_W-1:0] cur_coef,
  output logic              cur_tc,
  output logic [COEF_W-1:0] fwd_coef,
  output logic              fwd_tc
);

  localparam int WORD_W = COEF_W + 1;

  // stage_q[0] is the coefficient register; the rest are delay stages.
  logic [WORD_W-1:0] stage_q [DEC_MAX+1];
  logic [WORD_W-1:0] tap;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      for (int i = 0; i <= DEC_MAX; i++) stage_q[i] <= '0;
    end else if (load_q) begin
      stage_q[0] <= {coef_tc, coef_in};
      for (int i = 1; i <= DEC_MAX; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  always_comb begin
    tap = stage_q[0];
    for (int i = 0; i <= DEC_MAX; i++)
      if (int'(dec_q) == i) tap = stage_q[i];
  end

  assign cur_coef = stage_q[0][COEF_W-1:0];
  assign cur_tc   = stage_q[0][COEF_W];
  assign fwd_coef = tap[COEF_W-1:0];
  assign fwd_tc   = tap[COEF_W];

  // R4: a captured low enable freezes the whole coefficient chain
  a_r4_coef_frozen: assert property (@(posedge clk) disable iff (rst_q)
    !load_q |=> ($stable(stage_q[0]) && $stable(stage_q[DEC_MAX])));

endmodule

// File: rtl/fir_mac_pipe.sv
module fir_mac_pipe #(
  parameter int COEF_W = 8,
  parameter int DATA_W = 8,
  parameter int ACC_W  = 26
) (
  input  logic              clk,
  input  logic              rst_q,
  input  logic              clr_q,
  input  logic              sel_q,
  input  logic              xen_q,
  input  logic [COEF_W-1:0] coef_v,
  input  logic              coef_tc,
  input  logic [DATA_W-1:0] data_in,
  input  logic              data_tc,
  output logic [ACC_W-1:0]  result
);

  localparam int CX_W   = COEF_W + 1;
  localparam int DX_W   = DATA_W + 1;
  localparam int PROD_W = CX_W + DX_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  logic signed [CX_W-1:0]   c_s;
  logic signed [DX_W-1:0]   x_q;
  logic signed [PROD_W-1:0] prod, m0_q, m1_q;
  logic [ACC_W-1:0]         prod_ext, feedback, sum, acc_q, treg_q;

  assign c_s = {coef_tc & coef_v[COEF_W-1], coef_v};

  // Sample register: loads zero while the captured enable is low.
  always_ff @(posedge clk) begin
    if (rst_q || !xen_q) x_q <= '0;
    else                 x_q <= {data_tc & data_in[DATA_W-1], data_in};
  end

  assign prod = c_s * x_q;

  always_ff @(posedge clk) begin
    if (rst_q) begin
      m0_q <= '0;
      m1_q <= '0;
    end else begin
      m0_q <= prod;
      m1_q <= m0_q;
    end
  end

  assign prod_ext = {{EXT_W{m1_q[PROD_W-1]}}, m1_q};
  assign feedback = (clr_q && sel_q) ? '0 : acc_q;
  assign sum      = feedback + prod_ext;

  always_ff @(posedge clk) begin
    if (rst_q && clr_q) acc_q <= '0;
    else                acc_q <= sum;
  end

  always_ff @(posedge clk) begin
    if (rst_q)       treg_q <= '0;
    else if (!sel_q) treg_q <= sum;
  end

  assign result = treg_q;

  // R5: a zeroed sample reaches the second multiplier stage three clocks later
  a_r5_zero_product: assert property (@(posedge clk) disable iff (rst_q)
    !xen_q |-> ##3 (m1_q == '0));

  // R7: the hold register keeps its value in the clock after selection
  a_r7_result_held: assert property (@(posedge clk) disable iff (rst_q)
    sel_q |=> $stable(treg_q));

  // R7: a restart leaves only the incoming product in the accumulator
  a_r7_restart_from_product: assert property (@(posedge clk) disable iff (rst_q)
    (clr_q && sel_q) |=> (acc_q == $past(prod_ext)));

endmodule

// File: rtl/fir_mac_cell.sv
module fir_mac_cell #(
  parameter int COEF_W  = 8,
  parameter int DATA_W  = 8,
  parameter int ACC_W   = 26,
  parameter int DEC_MAX = 3,
  parameter int DEC_W   = $clog2(DEC_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_clr,
  input  logic              cell_sel,
  input  logic              coef_en,
  input  logic [COEF_W-1:0] coef_in,
  input  logic              coef_tc,
  input  logic              data_en,
  input  logic [DATA_W-1:0] data_in,
  input  logic              data_tc,
  input  logic [DEC_W-1:0]  dec_sel,
  output logic [COEF_W-1:0] coef_out,
  output logic              coef_tc_out,
  output logic [ACC_W-1:0]  result
);

  fir_cell_pkg::cell_ctl_t ctl_in, ctl_q;
  logic [DEC_W-1:0]        dec_q;
  logic [COEF_W-1:0]       cur_coef;
  logic                    cur_tc;

  always_comb begin
    ctl_in.rst     = rst;
    ctl_in.clr     = acc_clr;
    ctl_in.sel     = cell_sel;
    ctl_in.coef_en = coef_en;
    ctl_in.data_en = data_en;
  end

  fir_cell_ctl #(.DEC_W(DEC_W)) u_ctl (
    .clk    (clk),
    .ctl_in (ctl_in),
    .dec_in (dec_sel),
    .ctl_q  (ctl_q),
    .dec_q  (dec_q)
  );

  fir_coef_path #(.COEF_W(COEF_W), .DEC_MAX(DEC_MAX), .DEC_W(DEC_W)) u_coef (
    .clk      (clk),
    .rst_q    (ctl_q.rst),
    .load_q   (ctl_q.coef_en),
    .dec_q    (dec_q),
    .coef_in  (coef_in),
    .coef_tc  (coef_tc),
    .cur_coef (cur_coef),
    .cur_tc   (cur_tc),
    .fwd_coef (coef_out),
    .fwd_tc   (coef_tc_out)
  );

  fir_mac_pipe #(.COEF_W(COEF_W), .DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
    .clk     (clk),
    .rst_q   (ctl_q.rst),
    .clr_q   (ctl_q.clr),
    .sel_q   (ctl_q.sel),
    .xen_q   (ctl_q.data_en),
    .coef_v  (cur_coef),
    .coef_tc (cur_tc),
    .data_in (data_in),
    .data_tc (data_tc),
    .result  (result)
  );

endmodule

// File: tb/tb_fir_mac_cell.sv
module tb_fir_mac_cell;

  localparam longint MASK = (64'd1 << 26) - 1;

  logic        clk = 1'b0;
  logic        rst, acc_clr, cell_sel, coef_en, coef_tc, data_en, data_tc;
  logic [7:0]  coef_in, data_in;
  logic [1:0]  dec_sel;
  logic [7:0]  coef_out;
  logic        coef_tc_out;
  logic [25:0] result;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #4 clk = ~clk;

  fir_mac_cell dut (
    .clk(clk), .rst(rst), .acc_clr(acc_clr), .cell_sel(cell_sel),
    .coef_en(coef_en), .coef_in(coef_in), .coef_tc(coef_tc),
    .data_en(data_en), .data_in(data_in), .data_tc(data_tc),
    .dec_sel(dec_sel), .coef_out(coef_out), .coef_tc_out(coef_tc_out),
    .result(result)
  );

  // Vector layout: {coef_tc, coef[7:0], data_tc, data[7:0]}; groups of four
  localparam logic [17:0] VEC [16] = '{
    {1'b0, 8'd255, 1'b0, 8'd255}, {1'b0, 8'd1,   1'b0, 8'd200},
    {1'b0, 8'd128, 1'b0, 8'd2},   {1'b0, 8'd17,  1'b0, 8'd3},
    {1'b1, 8'h80,  1'b1, 8'h80},  {1'b1, 8'h7F,  1'b1, 8'h80},
    {1'b1, 8'hFF,  1'b1, 8'h01},  {1'b1, 8'h90,  1'b1, 8'h05},
    {1'b1, 8'h80,  1'b0, 8'hFF},  {1'b1, 8'hFF,  1'b0, 8'hFF},
    {1'b0, 8'hFF,  1'b1, 8'h80},  {1'b0, 8'd200, 1'b1, 8'h7F},
    {1'b1, 8'h85,  1'b0, 8'h40},  {1'b0, 8'h85,  1'b1, 8'hC0},
    {1'b1, 8'h00,  1'b1, 8'h80},  {1'b0, 8'h0A,  1'b1, 8'hFF}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // Inputs change 1 ns after a rising edge; outputs are read at the same point.
  task automatic step(input logic [7:0] c, input logic ctc,
                      input logic [7:0] x, input logic xtc);
    coef_in = c; coef_tc = ctc; data_in = x; data_tc = xtc;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) step(8'd0, 1'b0, 8'd0, 1'b0);
  endtask

  task automatic full_clear();
    rst = 1'b1; acc_clr = 1'b1;
    idle(1);
    rst = 1'b0; acc_clr = 1'b0;
    idle(1);
  endtask

  function automatic longint term(input logic [7:0] c, input logic ctc,
                                  input logic [7:0] x, input logic xtc);
    longint cv = ctc ? longint'($signed(c)) : longint'(c);
    longint xv = xtc ? longint'($signed(x)) : longint'(x);
    return cv * xv;
  endfunction

  // Products 60 then 9; select/clear strobes presented two clocks after the last
  // product of the first group.
  task automatic restart(input logic s, input logic c, input longint e6,
                         input longint ef, input string req);
    full_clear();
    step(8'd1, 0, 8'd10, 0); step(8'd2, 0, 8'd10, 0); step(8'd3, 0, 8'd10, 0);
    step(8'd4, 0, 8'd1, 0);  step(8'd5, 0, 8'd1, 0);
    cell_sel = s; acc_clr = c;
    idle(1);
    chk(req, longint'(result), 60);
    cell_sel = 1'b0; acc_clr = 1'b0;
    idle(1);
    chk(req, longint'(result), e6);
    idle(2);
    chk(req, longint'(result), ef);
  endtask

  initial begin
    rst = 1'b1; acc_clr = 1'b1; cell_sel = 1'b0;
    coef_en = 1'b1; data_en = 1'b1; dec_sel = 2'd0;
    coef_in = '0; coef_tc = 1'b0; data_in = '0; data_tc = 1'b0;
    idle(3);
    rst = 1'b0; acc_clr = 1'b0;
    idle(1);
    // R10: reset with clear leaves everything at zero
    chk("R10 reset result", longint'(result), 0);
    chk("R10 reset coef_out", longint'(coef_out), 0);
    chk("R10 reset coef_tc_out", longint'(coef_tc_out), 0);

    // R1: table of operand pairs, all format combinations
    begin
      longint e = 0;
      for (int i = 0; i < 16; i++) begin
        if (i % 4 == 0) begin full_clear(); e = 0; end
        step(VEC[i][16:9], VEC[i][17], VEC[i][7:0], VEC[i][8]);
        e += term(VEC[i][16:9], VEC[i][17], VEC[i][7:0], VEC[i][8]);
        if (i % 4 == 3) begin
          idle(4);
          chk($sformatf("R1 group %0d", i / 4), longint'(result), e & MASK);
          if (i == 3) begin
            full_clear();
            chk("R10 clear after sum", longint'(result), 0);
          end
        end
      end
    end

    // R3: latency of four register levels
    full_clear();
    step(8'd3, 0, 8'd7, 0);
    idle(2);
    chk("R3 before edge k+3", longint'(result), 0);
    idle(1);
    chk("R3 at edge k+3", longint'(result), 21);

    // R5: data enable takes effect one clock late and zeroes samples
    full_clear();
    data_en = 1'b0;
    step(8'd2, 0, 8'd10, 0);
    step(8'd9, 0, 8'd9, 0);
    data_en = 1'b1;
    step(8'd1, 0, 8'd1, 0);
    step(8'd1, 0, 8'd4, 0);
    idle(4);
    chk("R5 data enable", longint'(result), 24);

    // R4: coefficient enable takes effect one clock late and freezes C
    full_clear();
    coef_en = 1'b0;
    step(8'd5, 0, 8'd1, 0);
    step(8'd99, 0, 8'd2, 0);
    step(8'd99, 0, 8'd3, 0);
    coef_en = 1'b1;
    step(8'd99, 0, 8'd1, 0);
    step(8'd7, 0, 8'd1, 0);
    idle(4);
    chk("R4 coef enable", longint'(result), 42);

    // R7, R8: restart and hold
    restart(1'b1, 1'b1, 60, 9,  "R7 restart");
    restart(1'b0, 1'b1, 64, 69, "R8 clear without select");
    restart(1'b1, 1'b0, 60, 69, "R8 select without clear");

    // R2: wraps modulo 2^26
    full_clear();
    repeat (1100) step(8'd255, 0, 8'd255, 0);
    idle(4);
    chk("R2 wrap", longint'(result), (1100 * 65025) & MASK);

    // R9: reset alone clears registers but keeps the accumulator
    step(8'h5A, 0, 8'd0, 0);
    coef_en = 1'b0;
    rst = 1'b1;
    step(8'h5A, 0, 8'd0, 0);
    chk("R9 coef before reset", longint'(coef_out), 8'h5A);
    rst = 1'b0;
    step(8'h5A, 0, 8'd0, 0);
    chk("R9 hold cleared", longint'(result), 0);
    chk("R9 coef cleared", longint'(coef_out), 0);
    step(8'h5A, 0, 8'd0, 0);
    chk("R9 accumulator kept", longint'(result), (1100 * 65025) & MASK);
    coef_en = 1'b1;

    // R6: decimation delay on the forwarded coefficient and flag
    for (int d = 0; d < 4; d++) begin
      dec_sel = 2'(d);
      idle(2);
      for (int j = 0; j < 6; j++) begin
        step(8'(16 * d + j + 1), j[0], 8'd0, 0);
        if (j >= d) begin
          chk($sformatf("R6 coef d=%0d j=%0d", d, j), longint'(coef_out),
              longint'(16 * d + (j - d) + 1));
          chk($sformatf("R6 flag d=%0d j=%0d", d, j), longint'(coef_tc_out),
              longint'((j - d) % 2));
        end
      end
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule